// File: doc/BRIEF.md
# Core-Side Memory Interface Controller

This block is the slave end of a simple 32-bit processor bus with one shared path for instructions and data. It serves an on-chip RAM organised as 32-bit words. Each cycle the core drives an active-low request strobe and a sequential flag. The controller decodes that pair into one of four cycle kinds: non-sequential, sequential, internal or coprocessor transfer. Only the first two touch memory.

A sequential access continues the previous access. Its address equals the last address, or exceeds it by a halfword or by a word. Such an access completes at once. A non-sequential access, or any access after an idle spell, costs one wait cycle. During that cycle the core's clock is stopped and its request stays held. Transfers may be bytes, halfwords or words. A configuration input selects little- or big-endian byte-lane ordering. Narrow reads come back zero-extended in the low bits of the read bus. Misaligned, illegal-size and out-of-range accesses are refused with an abort and leave memory untouched. A lock input keeps the bus marked as held across a read-modify-write pair.

The control is a three-state machine:
- ST_IDLE is the state after reset or after an internal or coprocessor cycle. Any memory request here moves to ST_STALL.
- ST_ACTIVE is the state after a completed access. A sequential request that follows the previous address completes and stays in ST_ACTIVE. Any other memory request moves to ST_STALL. An internal or coprocessor cycle returns to ST_IDLE.
- ST_STALL drives wait high for one cycle. A held request then completes and moves to ST_ACTIVE. A dropped request returns to ST_IDLE.

Top module: `memif_ctrl`

## Requirements
- R1: The strobe pair {req_n, seq} decodes as 00 = non-sequential, 01 = sequential, 10 = internal, 11 = coprocessor transfer. Internal and coprocessor cycles write nothing to memory and leave rdata and abort unchanged, or abort low.
- R2: From ST_ACTIVE, a sequential cycle whose address equals the previous access address, or that address plus 2, or that address plus 4, completes with wait_o low. Its result appears in the cycle after the sampling clock edge.
- R3: size encodes 00 = byte, 01 = halfword, 10 = word. A word write followed by a word read at the same address returns the 32-bit value written.
- R4: A non-sequential cycle holds wait_o high for exactly one cycle. Its result appears in the following cycle. A cycle flagged sequential whose address does not follow the previous one is handled the same way.
- R5: The first access after reset, and the first access after an internal or coprocessor cycle, takes the one-cycle wait whatever the value of seq.
- R6: An access is refused when a halfword address has bit 0 set, when a word address has bits 1:0 non-zero, when size is 11, or when the address is at or above 4*DEPTH_WORDS. A refused access raises abort in its result cycle, returns rdata = 0 and leaves memory unmodified.
- R7: With big_end = 0, byte offset k maps to data bits 8k+7:8k and the halfword at offset 2 maps to bits 31:16. With big_end = 1, byte offset k maps to bits 31-8k:24-8k and the halfword at offset 0 maps to bits 31:16. A narrow read is zero-extended into the low bits of rdata. A narrow write takes its value from the low bits of wdata and changes only the addressed lanes.
- R8: bus_locked rises in the cycle after an access edge sampled with lock = 1. It stays high through further cycles while lock stays high, and falls in the cycle after any edge sampled with lock = 0.
- R9: During and straight after reset, rdata = 0 and wait_o, abort and bus_locked are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the access |
| req_n | input | 1 | Active-low memory request strobe |
| seq | input | 1 | Sequential flag, decoded together with req_n |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word |
| lock | input | 1 | Hold the bus across an atomic pair |
| big_end | input | 1 | 1 = big-endian lane ordering |
| wdata | input | 32 | Write data, with narrow values in the low bits |
| rdata | output | 32 | Read result, with narrow values zero-extended |
| wait_o | output | 1 | Stall request to the core |
| abort | output | 1 | Access refused |
| bus_locked | output | 1 | Bus held for an atomic sequence |

## Verification
Several address patterns exercise the sequence tracker: the same address again, a step of 2, a step of 4, and a jump while the sequential flag is set. Together they show whether the tracker accepts exactly the three legal successors. Internal and coprocessor cycles are placed between sequential accesses to confirm that an idle spell forces the wait, and an internal cycle driven with write data shows that memory and rdata stay untouched. The same stored word is read back by byte and by halfword under both endian settings, and narrow writes are read back as whole words, which tells lane-selection errors apart from extension errors. Refused accesses, including an address that would wrap onto word 0, are followed by readback of the memory they must not have changed.

// File: rtl/memif_pkg.sv
package memif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_STALL
    } fsm_state_t;

    typedef enum logic [1:0] {
        CYC_N,
        CYC_S,
        CYC_I,
        CYC_C
    } cyc_kind_t;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    // Strobe pair to cycle kind
    function automatic cyc_kind_t decode_cycle(input logic req_n, input logic seq);
        cyc_kind_t k;
        unique case ({req_n, seq})
            2'b00:   k = CYC_N;
            2'b01:   k = CYC_S;
            2'b10:   k = CYC_I;
            default: k = CYC_C;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/memif_cycle_fsm.sv
module memif_cycle_fsm
    import memif_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic              seq,
    input  logic [ADDR_W-1:0] addr,
    output logic              wait_o,
    output logic              fire
);

    localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

    fsm_state_t        state_q;
    fsm_state_t        state_d;
    cyc_kind_t         kind;
    logic [ADDR_W-1:0] prev_q;
    logic              follows;
    logic              is_mem;
    logic              fire_d;

    assign kind    = decode_cycle(req_n, seq);
    assign is_mem  = (kind == CYC_N) || (kind == CYC_S);
    assign follows = (addr == prev_q) ||
                     (addr == prev_q + STEP_HALF) ||
                     (addr == prev_q + STEP_WORD);

    // Transitions
    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_mem) state_d = ST_STALL;
            end
            ST_ACTIVE: begin
                unique case (kind)
                    CYC_S: begin
                        if (follows) begin
                            state_d = ST_ACTIVE;
                            fire_d  = 1'b1;
                        end else begin
                            state_d = ST_STALL;
                        end
                    end
                    CYC_N:   state_d = ST_STALL;
                    default: state_d = ST_IDLE;
                endcase
            end
            ST_STALL: begin
                if (is_mem) begin
                    state_d = ST_ACTIVE;
                    fire_d  = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (fire_d) prev_q <= addr;
        end
    end

    // Outputs
    always_comb begin
        wait_o = (state_q == ST_STALL);
        fire   = fire_d;
    end

endmodule

// File: rtl/memif_lane.sv
module memif_lane
    import memif_pkg::*;
(
    input  logic [1:0]  addr_lo,
    input  logic [1:0]  size,
    input  logic        big_end,
    input  logic [31:0] wdata,
    input  logic [31:0] rd_word,
    output logic [3:0]  byte_en,
    output logic [31:0] wr_word,
    output logic [31:0] rd_data,
    output logic        misaligned
);

    logic [1:0] byte_lane;
    logic       upper_half;

    always_comb begin
        byte_lane  = big_end ? (2'd3 - addr_lo) : addr_lo;
        upper_half = big_end ? ~addr_lo[1] : addr_lo[1];
    end

    always_comb begin
        misaligned = 1'b0;
        byte_en    = 4'b0000;
        wr_word    = wdata;
        rd_data    = 32'h0;
        unique case (size)
            SZ_BYTE: begin
                byte_en = 4'b0001 << byte_lane;
                wr_word = {4{wdata[7:0]}};
                rd_data = {24'h0, rd_word[8*byte_lane +: 8]};
            end
            SZ_HALF: begin
                misaligned = addr_lo[0];
                byte_en    = upper_half ? 4'b1100 : 4'b0011;
                wr_word    = {2{wdata[15:0]}};
                rd_data    = {16'h0, upper_half ? rd_word[31:16] : rd_word[15:0]};
            end
            SZ_WORD: begin
                misaligned = (addr_lo != 2'b00);
                byte_en    = 4'b1111;
                wr_word    = wdata;
                rd_data    = rd_word;
            end
            default: begin
                misaligned = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/memif_ram.sv
module memif_ram #(
    parameter int DEPTH_WORDS = 256,
    parameter int IDX_W       = $clog2(DEPTH_WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [3:0]       byte_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wr_word,
    output logic [31:0]      rd_word
);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH_WORDS];

        always_ff @(posedge clk) begin
            if (we && byte_en[g]) lane_mem[idx] <= wr_word[8*g +: 8];
        end

        assign rd_word[8*g +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/memif_ctrl.sv
module memif_ctrl
    import memif_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DEPTH_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              req_n,
    input  logic              seq,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic              lock,
    input  logic              big_end,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              wait_o,
    output logic              abort,
    output logic              bus_locked
);

    localparam int IDX_W   = $clog2(DEPTH_WORDS);
    localparam int RANGE_W = IDX_W + 2;

    logic             acc_fire;
    logic [3:0]       byte_en;
    logic [31:0]      wr_word;
    logic [31:0]      rd_word;
    logic [31:0]      rd_data;
    logic             misaligned;
    logic             out_of_range;
    logic             refused;
    logic             do_write;
    logic [IDX_W-1:0] idx;

    memif_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_n  (req_n),
        .seq    (seq),
        .addr   (addr),
        .wait_o (wait_o),
        .fire   (acc_fire)
    );

    memif_lane u_lane (
        .addr_lo    (addr[1:0]),
        .size       (size),
        .big_end    (big_end),
        .wdata      (wdata),
        .rd_word    (rd_word),
        .byte_en    (byte_en),
        .wr_word    (wr_word),
        .rd_data    (rd_data),
        .misaligned (misaligned)
    );

    assign idx          = addr[RANGE_W-1:2];
    assign out_of_range = (addr >> RANGE_W) != '0;
    assign refused      = misaligned || out_of_range;
    assign do_write     = acc_fire && wr && !refused;

    memif_ram #(.DEPTH_WORDS(DEPTH_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .we      (do_write),
        .byte_en (byte_en),
        .idx     (idx),
        .wr_word (wr_word),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata      <= 32'h0;
            abort      <= 1'b0;
            bus_locked <= 1'b0;
        end else begin
            abort <= acc_fire && refused;
            if (acc_fire) begin
                if (refused)  rdata <= 32'h0;
                else if (!wr) rdata <= rd_data;
            end
            if (!lock)                bus_locked <= 1'b0;
            else if (acc_fire)        bus_locked <= 1'b1;
        end
    end

endmodule

// File: rtl/memif_checker.sv
module memif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_n,
    input logic       lock,
    input logic [1:0] size,
    input logic [1:0] addr_lo,
    input logic       fire,
    input logic       wait_o,
    input logic       abort,
    input logic       bus_locked
);

    AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_n |-> !fire); // R1

    AST_SINGLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |=> !wait_o); // R4

    AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> !abort); // R4

    AST_RESTART_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && $past(req_n)) |=> wait_o); // R5

    AST_BAD_SIZE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && size == 2'b11) |=> abort); // R6

    AST_WORD_ALIGN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && size == 2'b10 && addr_lo != 2'b00) |=> abort); // R6

    AST_ABORT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(!req_n)); // R6

    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && lock) |=> bus_locked); // R8

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> !bus_locked); // R8

endmodule

bind memif_ctrl memif_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_n      (req_n),
    .lock       (lock),
    .size       (size),
    .addr_lo    (addr[1:0]),
    .fire       (acc_fire),
    .wait_o     (wait_o),
    .abort      (abort),
    .bus_locked (bus_locked)
);

// File: tb/tb_memif_ctrl.sv
module tb_memif_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] addr;
    logic        req_n;
    logic        seq;
    logic        wr;
    logic [1:0]  size;
    logic        lock;
    logic        big_end;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        wait_o;
    logic        abort;
    logic        bus_locked;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    memif_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .req_n      (req_n),
        .seq        (seq),
        .wr         (wr),
        .size       (size),
        .lock       (lock),
        .big_end    (big_end),
        .wdata      (wdata),
        .rdata      (rdata),
        .wait_o     (wait_o),
        .abort      (abort),
        .bus_locked (bus_locked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge and return at the falling edge of its result cycle
    task automatic access(input logic [31:0] a, input logic w, input logic [1:0] sz,
                          input logic [31:0] wd, input logic sq, input logic lk,
                          output int waits, output logic [31:0] rd, output logic ab);
        addr = a; wr = w; size = sz; wdata = wd; seq = sq; lock = lk; req_n = 1'b0;
        waits = 0;
        @(posedge clk); @(negedge clk);
        while (wait_o && waits < 4) begin
            waits++;
            @(posedge clk); @(negedge clk);
        end
        rd = rdata;
        ab = abort;
    endtask

    task automatic idle_cycle(input logic copro, input logic lk);
        req_n = 1'b1; seq = copro; lock = lk;
        wr = 1'b1; wdata = 32'hFFFF_FFFF; addr = 32'h0; size = 2'b10;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic test_reset();
        check("R9 rdata", rdata, 32'h0);
        check("R9 wait_o", 32'(wait_o), 32'd0);
        check("R9 abort", 32'(abort), 32'd0);
        check("R9 bus_locked", 32'(bus_locked), 32'd0);
    endtask

    task automatic test_nonseq();
        int w; logic [31:0] rd; logic ab;
        access(32'h0, 1'b1, 2'b10, 32'h1122_3344, 1'b0, 1'b0, w, rd, ab);
        check("R5 first access waits", 32'(w), 32'd1);
        access(32'h0, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R4 N cycle waits", 32'(w), 32'd1);
        check("R3 word readback", rd, 32'h1122_3344);
    endtask

    task automatic test_seq();
        int w; logic [31:0] rd; logic ab;
        access(32'h4, 1'b1, 2'b10, 32'hA5A5_0004, 1'b1, 1'b0, w, rd, ab);
        check("R2 +4 write no wait", 32'(w), 32'd0);
        access(32'h8, 1'b1, 2'b10, 32'h0BAD_F00D, 1'b1, 1'b0, w, rd, ab);
        check("R2 +4 second write no wait", 32'(w), 32'd0);
        access(32'h8, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0, w, rd, ab);
        check("R2 same address no wait", 32'(w), 32'd0);
        check("R2 same address data", rd, 32'h0BAD_F00D);
        access(32'hA, 1'b0, 2'b01, 32'h0, 1'b1, 1'b0, w, rd, ab);
        check("R2 +2 half no wait", 32'(w), 32'd0);
        check("R2 +2 half data", rd, 32'h0000_0BAD);
        access(32'h4, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0, w, rd, ab);
        check("R4 jump with seq waits", 32'(w), 32'd1);
        check("R4 jump data", rd, 32'hA5A5_0004);
    endtask

    task automatic test_idle();
        int w; logic [31:0] rd; logic ab;
        idle_cycle(1'b0, 1'b0);
        check("R1 I cycle keeps rdata", rdata, 32'hA5A5_0004);
        check("R1 I cycle abort low", 32'(abort), 32'd0);
        access(32'h8, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0, w, rd, ab);
        check("R5 after I waits", 32'(w), 32'd1);
        check("R5 after I data", rd, 32'h0BAD_F00D);
        idle_cycle(1'b1, 1'b0);
        check("R1 C cycle keeps rdata", rdata, 32'h0BAD_F00D);
        access(32'h8, 1'b0, 2'b10, 32'h0, 1'b1, 1'b0, w, rd, ab);
        check("R5 after C waits", 32'(w), 32'd1);
        access(32'h0, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R1 idle cycles wrote nothing", rd, 32'h1122_3344);
    endtask

    task automatic test_read_lanes();
        int w; logic [31:0] rd; logic ab;
        big_end = 1'b0;
        access(32'h10, 1'b1, 2'b10, 32'h1122_3344, 1'b0, 1'b0, w, rd, ab);
        access(32'h10, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 LE byte 0", rd, 32'h0000_0044);
        access(32'h13, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 LE byte 3", rd, 32'h0000_0011);
        access(32'h12, 1'b0, 2'b01, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 LE half 2", rd, 32'h0000_1122);
        big_end = 1'b1;
        access(32'h10, 1'b0, 2'b00, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 BE byte 0", rd, 32'h0000_0011);
        access(32'h12, 1'b0, 2'b01, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 BE half 2", rd, 32'h0000_3344);
        access(32'h10, 1'b0, 2'b01, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 BE half 0", rd, 32'h0000_1122);
        access(32'h10, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 BE word", rd, 32'h1122_3344);
        big_end = 1'b0;
    endtask

    task automatic test_write_lanes();
        int w; logic [31:0] rd; logic ab;
        big_end = 1'b0;
        access(32'h20, 1'b1, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        access(32'h21, 1'b1, 2'b00, 32'h1234_56AA, 1'b0, 1'b0, w, rd, ab);
        access(32'h20, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 LE byte write lane 1", rd, 32'h0000_AA00);
        big_end = 1'b1;
        access(32'h20, 1'b1, 2'b00, 32'h0000_0055, 1'b0, 1'b0, w, rd, ab);
        access(32'h22, 1'b1, 2'b01, 32'hFFFF_7788, 1'b0, 1'b0, w, rd, ab);
        big_end = 1'b0;
        access(32'h20, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R7 BE byte and half writes", rd, 32'h5500_7788);
    endtask

    task automatic test_abort();
        int w; logic [31:0] rd; logic ab;
        access(32'h22, 1'b1, 2'b10, 32'hDEAD_BEEF, 1'b0, 1'b0, w, rd, ab);
        check("R6 misaligned word abort", 32'(ab), 32'd1);
        check("R6 abort rdata zero", rd, 32'h0);
        access(32'h20, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R6 memory kept after abort", rd, 32'h5500_7788);
        check("R6 legal access no abort", 32'(ab), 32'd0);
        access(32'h21, 1'b0, 2'b01, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R6 misaligned half abort", 32'(ab), 32'd1);
        access(32'h20, 1'b0, 2'b11, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R6 size 11 abort", 32'(ab), 32'd1);
        access(32'h400, 1'b1, 2'b10, 32'hCAFE_F00D, 1'b0, 1'b0, w, rd, ab);
        check("R6 out of range abort", 32'(ab), 32'd1);
        access(32'h0, 1'b0, 2'b10, 32'h0, 1'b0, 1'b0, w, rd, ab);
        check("R6 no wrap write", rd, 32'h1122_3344);
    endtask

    task automatic test_lock();
        int w; logic [31:0] rd; logic ab;
        access(32'h0, 1'b0, 2'b10, 32'h0, 1'b0, 1'b1, w, rd, ab);
        check("R8 locked after access", 32'(bus_locked), 32'd1);
        idle_cycle(1'b0, 1'b1);
        check("R8 held over idle", 32'(bus_locked), 32'd1);
        access(32'h0, 1'b1, 2'b10, 32'h1122_3344, 1'b0, 1'b1, w, rd, ab);
        check("R8 held over write", 32'(bus_locked), 32'd1);
        idle_cycle(1'b0, 1'b0);
        check("R8 released", 32'(bus_locked), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_n = 1'b1; seq = 1'b0; wr = 1'b0; size = 2'b10;
        lock = 1'b0; big_end = 1'b0; wdata = 32'h0; addr = 32'h0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_nonseq();
        test_seq();
        test_idle();
        test_read_lanes();
        test_write_lanes();
        test_abort();
        test_lock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule